// File: doc/BRIEF.md
# Asynchronous Serial Port with Reload-Counter Bit Clock

This block is a full-duplex asynchronous serial port for an 8-bit data path. Software sets it up through three write-only registers: a control register, a reload value and a transmit data register. Received data and status come back on dedicated output ports. The frame starts with a low start bit. Eight data bits follow, least significant first. An even parity bit can follow the data. A high stop bit ends the frame. The line rests high.

Each direction has its own bit clock. A 3-bit prescale code divides the system clock by 2^code. The prescaled clock then drives an 8-bit up-counter. The counter starts at the reload value and returns to it after it passes 0xFF. A wrap of the counter marks half a bit, so one bit lasts 2^code × 2 × (256 − reload) system clocks. The transmitter restarts its bit clock when a frame is loaded. The receiver restarts its bit clock on the falling edge of a start bit. It then checks the start bit at its midpoint and samples every later bit at its midpoint. Setting the enable for a direction gives that direction's pin to the serial port, and the pin-ownership outputs tell the surrounding port logic which pins it no longer owns.

Top module: `uart_reload`

## Requirements
- R1: A transmitted frame is a low start bit, then the data bits least significant first, then an optional parity bit, then one high stop bit. `txPin` is high whenever `txBusy` is low.
- R2: Every transmitted bit lasts 2^code × 2 × (256 − reload) clock cycles. Here code is control bits [6:4] and reload is the value written to address 1.
- R3: When control bit 2 is set, the transmitter sends an even parity bit after the data, which gives an 11-bit frame. When bit 2 is clear, the frame has 10 bits.
- R4: `txBusy` rises in the cycle after a write to address 2 and stays high until the stop bit has been fully sent. In the cycle where `txBusy` falls, `txIrq` pulses high for exactly one cycle.
- R5: A write to address 2 while `txBusy` is high is ignored. A write to address 2 while the transmitter is disabled (control bit 0 = 0) is also ignored.
- R6: A received frame leaves its data on `rxData`, sets `rxReady` and pulses `rxIrq` for one cycle. A one-cycle `rxAck` clears `rxReady`.
- R7: When control bit 3 is set, the receiver expects an even parity bit. On a mismatch it sets `parityErr`, and it still stores the data.
- R8: A stop bit sampled low sets `frameErr`, and the data is still stored. Each completed frame rewrites both error flags.
- R9: A start bit that is high again at its midpoint is discarded. No data is stored, no interrupt is raised, and the receiver goes back to watching for a new start edge.
- R10: `txPinUart` follows control bit 0 (transmit enable) and `rxPinUart` follows control bit 1 (receive enable). The receiver acts only while bit 1 is set.
- R11: After reset, `txPin` is high, and `txBusy`, `rxReady`, `parityErr`, `frameErr`, `txPinUart` and `rxPinUart` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 control, 1 reload, 2 transmit data |
| wrData | input | 8 | Write data |
| rxAck | input | 1 | Read acknowledge; clears the receive-ready flag |
| rxPin | input | 1 | Serial receive line |
| txPin | output | 1 | Serial transmit line |
| txPinUart | output | 1 | High while the transmit pin belongs to the serial port |
| rxPinUart | output | 1 | High while the receive pin belongs to the serial port |
| txBusy | output | 1 | Frame being shifted out |
| rxReady | output | 1 | Received byte waiting |
| rxData | output | 8 | Last received byte |
| parityErr | output | 1 | Parity mismatch in the last frame |
| frameErr | output | 1 | Low stop bit in the last frame |
| txIrq | output | 1 | One-cycle pulse at the end of a transmit frame |
| rxIrq | output | 1 | One-cycle pulse when a byte is stored |

## Verification
The properties assume that `rxAck` is a single-cycle strobe and that a transmit write is not counted as a new frame while `txBusy` is high. The stimulus only ever raises `rxAck` for one cycle, when the bench is about to consume a byte. It changes the control and reload registers only between frames, because the bit clock reads them every cycle. Every frame the bench drives onto `rxPin` keeps each bit level steady for a full bit time. This matches the midpoint sampling the receiver relies on. The only exception is the deliberate short start-bit glitch.

// File: rtl/uart_reload_pkg.sv
package uart_reload_pkg;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_TXDATA = 2'd2;

  // control register field positions
  localparam int CTRL_TXEN   = 0;
  localparam int CTRL_RXEN   = 1;
  localparam int CTRL_TXPAR  = 2;
  localparam int CTRL_RXPAR  = 3;
  localparam int CTRL_PRESC  = 4;

  // one-cycle requests from the sequencer to the datapath
  typedef struct packed {
    logic txLoad;
    logic txAdvance;
    logic txFinish;
    logic rxArm;
    logic rxDataBit;
    logic rxParBit;
    logic rxFinish;
  } strobe_t;

  typedef enum logic {TX_IDLE, TX_RUN} txState_t;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rxState_t;

endpackage

// File: rtl/uart_reload_baud.sv
module uart_reload_baud #(
  parameter int PRESC_W  = 3,
  parameter int RELOAD_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                restart,
  input  logic [PRESC_W-1:0]  presc,
  input  logic [RELOAD_W-1:0] reload,
  output logic                halfTick
);

  localparam int PCNT_W = (2 ** PRESC_W) - 1;

  logic [PCNT_W-1:0]   preCnt;
  logic [PCNT_W-1:0]   preLimit;
  logic [RELOAD_W-1:0] divCnt;
  logic                preWrap;

  assign preLimit = (PCNT_W'(1) << presc) - PCNT_W'(1);
  assign preWrap  = (preCnt == preLimit);
  assign halfTick = !restart && preWrap && (divCnt == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (restart) begin
      preCnt <= '0;
      divCnt <= reload;
    end else if (preWrap) begin
      preCnt <= '0;
      divCnt <= (divCnt == '1) ? reload : divCnt + RELOAD_W'(1);
    end else begin
      preCnt <= preCnt + PCNT_W'(1);
    end
  end

endmodule

// File: rtl/uart_reload_ctrl.sv
module uart_reload_ctrl
  import uart_reload_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    txGo,
  input  logic    txHalf,
  input  logic    rxHalf,
  input  logic    rxBit,
  input  logic    rxFall,
  input  logic    txParEn,
  input  logic    rxParEn,
  input  logic    rxEn,
  output strobe_t stb,
  output logic    txBusy
);

  localparam int IDX_W = $clog2(DATA_W + 3);

  txState_t         txState;
  logic             txPhase;
  logic             txPar;
  logic [IDX_W-1:0] txIdx;
  logic [IDX_W-1:0] txLastIdx;

  rxState_t         rxState;
  logic             rxPhase;
  logic             rxPar;
  logic [IDX_W-1:0] rxIdx;
  logic [IDX_W-1:0] rxLastIdx;

  assign txLastIdx = txPar ? IDX_W'(DATA_W + 2) : IDX_W'(DATA_W + 1);
  assign rxLastIdx = rxPar ? IDX_W'(DATA_W + 1) : IDX_W'(DATA_W);
  assign txBusy    = (txState == TX_RUN);

  always_comb begin
    stb = '0;
    stb.txLoad = (txState == TX_IDLE) && txGo;
    if (txState == TX_RUN && txHalf && txPhase) begin
      if (txIdx == txLastIdx) stb.txFinish  = 1'b1;
      else                    stb.txAdvance = 1'b1;
    end
    stb.rxArm = (rxState == RX_IDLE) && rxEn && rxFall;
    if (rxState == RX_BITS && rxHalf && rxPhase && rxEn) begin
      if (rxIdx < IDX_W'(DATA_W))         stb.rxDataBit = 1'b1;
      else if (rxIdx == rxLastIdx)        stb.rxFinish  = 1'b1;
      else                                stb.rxParBit  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txPhase <= 1'b0;
      txPar   <= 1'b0;
      txIdx   <= '0;
    end else if (stb.txLoad) begin
      txState <= TX_RUN;
      txPhase <= 1'b0;
      txPar   <= txParEn;
      txIdx   <= '0;
    end else if (txState == TX_RUN && txHalf) begin
      txPhase <= ~txPhase;
      if (stb.txFinish)       txState <= TX_IDLE;
      else if (stb.txAdvance) txIdx   <= txIdx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxPhase <= 1'b0;
      rxPar   <= 1'b0;
      rxIdx   <= '0;
    end else if (!rxEn) begin
      rxState <= RX_IDLE;
    end else begin
      case (rxState)
        RX_IDLE: if (stb.rxArm) begin
          rxState <= RX_START;
          rxPar   <= rxParEn;
        end
        RX_START: if (rxHalf) begin
          rxState <= rxBit ? RX_IDLE : RX_BITS;
          rxPhase <= 1'b0;
          rxIdx   <= '0;
        end
        RX_BITS: if (rxHalf) begin
          rxPhase <= ~rxPhase;
          if (rxPhase) begin
            rxIdx <= rxIdx + IDX_W'(1);
            if (stb.rxFinish) rxState <= RX_IDLE;
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_reload_dp.sv
module uart_reload_dp
  import uart_reload_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RELOAD_W = 8,
  parameter int PRESC_W  = 3,
  parameter int BUS_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic              rxAck,
  input  logic              rxPin,
  input  strobe_t           stb,
  input  logic              txBusy,
  output logic              txGo,
  output logic              txHalf,
  output logic              rxHalf,
  output logic              rxBit,
  output logic              rxFall,
  output logic              txParEn,
  output logic              rxParEn,
  output logic              rxEn,
  output logic              txPin,
  output logic              txPinUart,
  output logic              rxPinUart,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              parityErr,
  output logic              frameErr,
  output logic              txIrq,
  output logic              rxIrq
);

  logic                txEnQ;
  logic [PRESC_W-1:0]  prescQ;
  logic [RELOAD_W-1:0] reloadQ;
  logic [DATA_W:0]     txSh;
  logic [DATA_W-1:0]   rxSh;
  logic                rxS1, rxS2, rxS3;
  logic                rxParQ;
  logic [1:0]          baudRestart;
  logic [1:0]          baudTick;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEnQ   <= 1'b0;
      rxEn    <= 1'b0;
      txParEn <= 1'b0;
      rxParEn <= 1'b0;
      prescQ  <= '0;
      reloadQ <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_CTRL) begin
        txEnQ   <= wrData[CTRL_TXEN];
        rxEn    <= wrData[CTRL_RXEN];
        txParEn <= wrData[CTRL_TXPAR];
        rxParEn <= wrData[CTRL_RXPAR];
        prescQ  <= wrData[CTRL_PRESC +: PRESC_W];
      end else if (wrAddr == ADDR_RELOAD) begin
        reloadQ <= wrData[RELOAD_W-1:0];
      end
    end
  end

  assign txPinUart = txEnQ;
  assign rxPinUart = rxEn;
  assign txGo      = wrEn && (wrAddr == ADDR_TXDATA) && txEnQ && !txBusy;

  // one bit clock per direction: index 0 transmit, index 1 receive
  assign baudRestart = {stb.rxArm, stb.txLoad};
  for (genvar g = 0; g < 2; g++) begin : g_baud
    uart_reload_baud #(.PRESC_W(PRESC_W), .RELOAD_W(RELOAD_W)) u_baud (
      .clk      (clk),
      .rstN     (rstN),
      .restart  (baudRestart[g]),
      .presc    (prescQ),
      .reload   (reloadQ),
      .halfTick (baudTick[g])
    );
  end
  assign txHalf = baudTick[0];
  assign rxHalf = baudTick[1];

  // transmit shifter: data, then parity or stop, then ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh  <= '1;
      txPin <= 1'b1;
      txIrq <= 1'b0;
    end else begin
      txIrq <= stb.txFinish;
      if (stb.txLoad) begin
        txSh  <= {txParEn ? ^wrData[DATA_W-1:0] : 1'b1, wrData[DATA_W-1:0]};
        txPin <= 1'b0;
      end else if (stb.txAdvance) begin
        txPin <= txSh[0];
        txSh  <= {1'b1, txSh[DATA_W:1]};
      end else if (stb.txFinish) begin
        txPin <= 1'b1;
      end
    end
  end

  // receive line synchroniser and edge detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxS1 <= 1'b1;
      rxS2 <= 1'b1;
      rxS3 <= 1'b1;
    end else begin
      rxS1 <= rxPin;
      rxS2 <= rxS1;
      rxS3 <= rxS2;
    end
  end
  assign rxBit  = rxS2;
  assign rxFall = rxS3 && !rxS2;

  // receive shifter and result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh      <= '0;
      rxParQ    <= 1'b0;
      rxData    <= '0;
      rxReady   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      rxIrq     <= 1'b0;
    end else begin
      rxIrq <= stb.rxFinish;
      if (stb.rxDataBit) rxSh   <= {rxBit, rxSh[DATA_W-1:1]};
      if (stb.rxParBit)  rxParQ <= rxBit;
      if (stb.rxFinish) begin
        rxData    <= rxSh;
        frameErr  <= !rxBit;
        parityErr <= rxParEn && ((^rxSh) != rxParQ);
        rxReady   <= 1'b1;
      end else if (rxAck) begin
        rxReady   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_reload.sv
module uart_reload
  import uart_reload_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RELOAD_W = 8,
  parameter int PRESC_W  = 3,
  localparam int CTRL_W  = CTRL_PRESC + PRESC_W,
  localparam int BUS_W   = (DATA_W >= RELOAD_W && DATA_W >= CTRL_W) ? DATA_W :
                           (RELOAD_W >= CTRL_W) ? RELOAD_W : CTRL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic              rxAck,
  input  logic              rxPin,
  output logic              txPin,
  output logic              txPinUart,
  output logic              rxPinUart,
  output logic              txBusy,
  output logic              rxReady,
  output logic [DATA_W-1:0] rxData,
  output logic              parityErr,
  output logic              frameErr,
  output logic              txIrq,
  output logic              rxIrq
);

  strobe_t stb;
  logic    txGo, txHalf, rxHalf, rxBit, rxFall, txParEn, rxParEn, rxEn;

  uart_reload_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .txGo    (txGo),
    .txHalf  (txHalf),
    .rxHalf  (rxHalf),
    .rxBit   (rxBit),
    .rxFall  (rxFall),
    .txParEn (txParEn),
    .rxParEn (rxParEn),
    .rxEn    (rxEn),
    .stb     (stb),
    .txBusy  (txBusy)
  );

  uart_reload_dp #(
    .DATA_W(DATA_W), .RELOAD_W(RELOAD_W), .PRESC_W(PRESC_W), .BUS_W(BUS_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rxAck     (rxAck),
    .rxPin     (rxPin),
    .stb       (stb),
    .txBusy    (txBusy),
    .txGo      (txGo),
    .txHalf    (txHalf),
    .rxHalf    (rxHalf),
    .rxBit     (rxBit),
    .rxFall    (rxFall),
    .txParEn   (txParEn),
    .rxParEn   (rxParEn),
    .rxEn      (rxEn),
    .txPin     (txPin),
    .txPinUart (txPinUart),
    .rxPinUart (rxPinUart),
    .rxData    (rxData),
    .rxReady   (rxReady),
    .parityErr (parityErr),
    .frameErr  (frameErr),
    .txIrq     (txIrq),
    .rxIrq     (rxIrq)
  );

endmodule

// File: rtl/uart_reload_chk.sv
module uart_reload_chk (
  input logic clk,
  input logic rstN,
  input logic txPin,
  input logic txBusy,
  input logic txIrq,
  input logic rxIrq,
  input logic rxReady,
  input logic rxAck
);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txPin);

  p_start_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !txPin);

  p_irq_at_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> (!txBusy && $past(txBusy)));

  p_irq_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |=> !txIrq);

  p_rx_irq_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> rxReady);

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxAck |=> (!rxReady || rxIrq));

endmodule

bind uart_reload uart_reload_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .txPin   (txPin),
  .txBusy  (txBusy),
  .txIrq   (txIrq),
  .rxIrq   (rxIrq),
  .rxReady (rxReady),
  .rxAck   (rxAck)
);

// File: tb/uart_reload_bench.sv
`timescale 1ns/1ps
module uart_reload_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       rxAck = 1'b0;
  logic       benchRx = 1'b1;
  logic       useLoop = 1'b1;
  logic       rxPin;
  logic       txPin, txPinUart, rxPinUart, txBusy, rxReady, parityErr, frameErr, txIrq, rxIrq;
  logic [7:0] rxData;

  int nApplied = 0;
  int nMiss = 0;
  int txIrqCnt = 0;
  int rxIrqCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign rxPin = useLoop ? txPin : benchRx;

  uart_reload u_uart_reload (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rxAck(rxAck), .rxPin(rxPin), .txPin(txPin), .txPinUart(txPinUart),
    .rxPinUart(rxPinUart), .txBusy(txBusy), .rxReady(rxReady), .rxData(rxData),
    .parityErr(parityErr), .frameErr(frameErr), .txIrq(txIrq), .rxIrq(rxIrq)
  );

  always @(negedge clk) begin
    if (txIrq) txIrqCnt++;
    if (rxIrq) rxIrqCnt++;
  end

  // {prescale code, reload, parity enable, data}
  localparam logic [19:0] VECS [8] = '{
    {3'd0, 8'hFC, 1'b0, 8'hA5},
    {3'd0, 8'hFC, 1'b1, 8'h01},
    {3'd1, 8'hFE, 1'b1, 8'h3C},
    {3'd2, 8'hFF, 1'b0, 8'h00},
    {3'd0, 8'hF8, 1'b1, 8'hFF},
    {3'd3, 8'hFE, 1'b0, 8'h80},
    {3'd0, 8'hF0, 1'b1, 8'h96},
    {3'd4, 8'hFF, 1'b1, 8'h7E}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nApplied++;
    if (act !== exp) begin
      nMiss++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    rxAck = 1'b1;
    @(posedge clk);
    #1 rxAck = 1'b0;
  endtask

  // control byte: [0] tx enable, [1] rx enable, [2] tx parity, [3] rx parity, [6:4] prescale
  function automatic logic [7:0] ctrlByte(input logic [2:0] code, input logic par,
                                          input logic txe, input logic rxe);
    return {1'b0, code, par, par, rxe, txe};
  endfunction

  task automatic loopFrame(input logic [2:0] code, input logic [7:0] rel,
                           input logic par, input logic [7:0] data);
    int h = (1 << code) * (256 - rel);
    int nb = par ? 11 : 10;
    int t0, r0;
    logic expBit;
    useLoop = 1'b1;
    wr(2'd0, ctrlByte(code, par, 1'b1, 1'b1));
    wr(2'd1, rel);
    t0 = txIrqCnt; r0 = rxIrqCnt;
    wr(2'd2, data);
    for (int i = 0; i < nb; i++) begin
      repeat (h) @(posedge clk);
      #1;
      if (i == 0) expBit = 1'b0;
      else if (i <= 8) expBit = data[i-1];
      else if (i == 9 && par) expBit = ^data;
      else expBit = 1'b1;
      if (i == 9 && par) check("R3 parity bit", txPin, expBit);
      else check($sformatf("R1 R2 bit %0d of %h", i, data), txPin, expBit);
      if (i == 0) check("R4 busy in frame", txBusy, 1'b1);
      repeat (h) @(posedge clk);
    end
    #1;
    check("R4 busy after stop", txBusy, 1'b0);
    repeat (12) @(posedge clk);
    #1;
    check("R4 tx irq count", txIrqCnt - t0, 1);
    check("R6 rx data", rxData, data);
    check("R6 rx ready", rxReady, 1'b1);
    check("R6 rx irq count", rxIrqCnt - r0, 1);
    check("R7 no parity error", parityErr, 1'b0);
    check("R8 no frame error", frameErr, 1'b0);
    ack();
    check("R6 ack clears ready", rxReady, 1'b0);
  endtask

  task automatic sendRx(input int h, input logic [7:0] data, input logic withPar,
                        input logic parBit, input logic stopBit);
    @(posedge clk); #1 benchRx = 1'b0;
    repeat (2 * h) @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      #1 benchRx = data[i];
      repeat (2 * h) @(posedge clk);
    end
    if (withPar) begin
      #1 benchRx = parBit;
      repeat (2 * h) @(posedge clk);
    end
    #1 benchRx = stopBit;
    repeat (2 * h) @(posedge clk);
    #1 benchRx = 1'b1;
    repeat (2 * h) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nMiss++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nApplied, nMiss);
      $finish;
    end
  end

  initial begin
    int r0, t0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    // R11 reset state
    check("R11 txPin", txPin, 1'b1);
    check("R11 txBusy", txBusy, 1'b0);
    check("R11 rxReady", rxReady, 1'b0);
    check("R11 parityErr", parityErr, 1'b0);
    check("R11 frameErr", frameErr, 1'b0);
    check("R11 txPinUart", txPinUart, 1'b0);
    check("R11 rxPinUart", rxPinUart, 1'b0);

    // R10 pin ownership
    wr(2'd0, ctrlByte(3'd0, 1'b0, 1'b1, 1'b0));
    check("R10 tx owns", txPinUart, 1'b1);
    check("R10 rx not owned", rxPinUart, 1'b0);
    wr(2'd0, ctrlByte(3'd0, 1'b0, 1'b0, 1'b1));
    check("R10 tx released", txPinUart, 1'b0);
    check("R10 rx owns", rxPinUart, 1'b1);

    // R5 write while transmitter disabled
    wr(2'd1, 8'hFC);
    wr(2'd2, 8'h77);
    @(posedge clk); #1;
    check("R5 disabled write not busy", txBusy, 1'b0);
    check("R5 disabled write line high", txPin, 1'b1);

    // vector table
    foreach (VECS[k]) loopFrame(VECS[k][19:17], VECS[k][16:9], VECS[k][8], VECS[k][7:0]);

    // R5 write while busy
    wr(2'd0, ctrlByte(3'd0, 1'b0, 1'b1, 1'b1));
    wr(2'd1, 8'hFC);
    t0 = txIrqCnt; r0 = rxIrqCnt;
    wr(2'd2, 8'hA1);
    repeat (10) @(posedge clk);
    wr(2'd2, 8'h5E);
    repeat (150) @(posedge clk); #1;
    check("R5 busy write ignored data", rxData, 8'hA1);
    check("R5 one tx frame only", txIrqCnt - t0, 1);
    check("R5 one rx frame only", rxIrqCnt - r0, 1);
    check("R5 idle after", txBusy, 1'b0);
    ack();

    // R7 parity error from driven line, half bit = 8 clocks
    useLoop = 1'b0;
    wr(2'd0, ctrlByte(3'd0, 1'b1, 1'b0, 1'b1));
    wr(2'd1, 8'hF8);
    sendRx(8, 8'h35, 1'b1, 1'b1, 1'b1);
    check("R7 data kept", rxData, 8'h35);
    check("R7 parity error", parityErr, 1'b1);
    check("R7 no frame error", frameErr, 1'b0);
    check("R7 ready", rxReady, 1'b1);
    ack();

    // R8 framing error
    wr(2'd0, ctrlByte(3'd0, 1'b0, 1'b0, 1'b1));
    sendRx(8, 8'hC3, 1'b0, 1'b0, 1'b0);
    check("R8 data kept", rxData, 8'hC3);
    check("R8 frame error", frameErr, 1'b1);
    check("R8 parity clear", parityErr, 1'b0);
    ack();

    // R9 short start glitch
    r0 = rxIrqCnt;
    @(posedge clk); #1 benchRx = 1'b0;
    repeat (3) @(posedge clk);
    #1 benchRx = 1'b1;
    repeat (60) @(posedge clk); #1;
    check("R9 glitch no ready", rxReady, 1'b0);
    check("R9 glitch no irq", rxIrqCnt - r0, 0);
    check("R9 glitch data unchanged", rxData, 8'hC3);
    sendRx(8, 8'h5A, 1'b0, 1'b0, 1'b1);
    check("R9 next frame data", rxData, 8'h5A);
    check("R8 errors rewritten", frameErr, 1'b0);
    check("R6 ready after glitch", rxReady, 1'b1);

    // R10 receiver disabled ignores line
    ack();
    r0 = rxIrqCnt;
    wr(2'd0, ctrlByte(3'd0, 1'b0, 1'b0, 1'b0));
    sendRx(8, 8'h11, 1'b0, 1'b0, 1'b1);
    check("R10 disabled rx no irq", rxIrqCnt - r0, 0);
    check("R10 disabled rx data kept", rxData, 8'h5A);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nApplied, nMiss);
    $finish;
  end

endmodule